// File: doc/BRIEF.md
# Audio Frame Sequencer

This block paces the slow-rate parts of an audio unit. It counts CPU cycle enables and emits one-clock quarter-frame and half-frame strobes. Envelope, linear-counter, length-counter and sweep logic elsewhere use these strobes as their timebase. In the four-step mode it also raises a frame interrupt at the end of each sequence. The five-step mode runs a longer sequence and never interrupts.

Software changes mode with a mode-register write. The new mode and interrupt-inhibit bits wait in shadow registers. The sequencer restarts a few CPU cycles later, and the wait depends on whether the write landed on an even or an odd CPU cycle. A status-register read returns the interrupt flag and acknowledges it. An inhibit write also drops it at once.

Top module: `apu_frame_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, qtr_pulse, half_pulse, frame_irq and irq_status are all 0. The sequencer starts in four-step mode with the interrupt allowed and the CPU cycle parity even.
- R2: In four-step mode, qtr_pulse is high for one clock after the enable that brings the count of enables since restart to 3729, 7457, 11186 and 14915. The count then restarts, so the sequence repeats every 14915 enables.
- R3: half_pulse is high together with qtr_pulse, and only at counts 7457 and 14915 in four-step mode, or 7457 and 18641 in five-step mode.
- R4: In four-step mode with the interrupt not inhibited, frame_irq sets on the clock after the 14915th enable and stays set until it is acknowledged.
- R5: In five-step mode, quarter strobes fall at counts 3729, 7457, 11186 and 18641, and nothing happens at 14915. The sequence repeats every 18641 enables, and frame_irq is never set by the sequencer.
- R6: mode_bits[1] is the five-step select (data bit 7) and mode_bits[0] the interrupt inhibit (data bit 6). A write takes effect on the 3rd enable after the write clock if an even number of enables had occurred before it, and on the 4th otherwise. Until then the old mode keeps running.
- R7: On the enable where a write takes effect, the count restarts at 0. If five-step was selected, qtr_pulse and half_pulse both fire for that enable. For four-step they stay low.
- R8: A mode write with mode_bits[0]=1 clears frame_irq on the next clock, without the delay. Once the inhibit has been applied, the end of a four-step sequence does not set frame_irq.
- R9: A stat_rd clock loads irq_status with the frame_irq value seen in that clock and clears frame_irq. If the sequence end falls in the same clock, the set wins.
- R10: A second mode write while a change is pending discards the first. The delay restarts from the second write with the second write's bits.
- R11: A clock with cyc_en low advances neither the count, the parity nor a pending delay, and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | One CPU cycle elapses on this clock |
| mode_wr | input | 1 | Mode-register write strobe |
| mode_bits | input | 2 | [1] five-step select, [0] interrupt inhibit |
| stat_rd | input | 1 | Status-register read strobe |
| qtr_pulse | output | 1 | Quarter-frame strobe |
| half_pulse | output | 1 | Half-frame strobe |
| frame_irq | output | 1 | Frame interrupt level |
| irq_status | output | 1 | Interrupt bit returned by the last status read |

## Verification
The assertions assume that every input is synchronous and sampled only at the rising edge. They do not assume that the strobes are exclusive: a read may share a clock with the sequence end, and a mode write may share a clock with an enable. For that reason the read-clear property excludes the clock that sets the flag. The stimulus changes inputs only on the falling edge. It mixes overlapping read, write and enable strobes at random with directed writes placed on chosen parities, and with reads placed exactly on the sequence end.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef struct packed {
    logic qtr;
    logic half;
    logic irq;
    logic wrap;
  } fseq_tick_t;

  // Events for the enable that brings the running count to k.
  function automatic fseq_tick_t fseq_decode(input logic five, input int unsigned k,
                                             input int unsigned s1, input int unsigned s2,
                                             input int unsigned s3, input int unsigned s4,
                                             input int unsigned s5);
    fseq_tick_t t;
    t = '0;
    if (k == s1 || k == s3) t.qtr = 1'b1;
    if (k == s2) begin
      t.qtr  = 1'b1;
      t.half = 1'b1;
    end
    if (!five && k == s4) begin
      t.qtr  = 1'b1;
      t.half = 1'b1;
      t.irq  = 1'b1;
      t.wrap = 1'b1;
    end
    if (five && k == s5) begin
      t.qtr  = 1'b1;
      t.half = 1'b1;
      t.wrap = 1'b1;
    end
    return t;
  endfunction

endpackage

// File: rtl/fseq_delay.sv
module fseq_delay #(
  parameter int EVEN_DELAY = 3,
  parameter int ODD_DELAY  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_en,
  input  logic       mode_wr,
  input  logic [1:0] mode_bits,
  output logic       apply,
  output logic       sh_five,
  output logic       sh_inh
);
  localparam int DW = $clog2(ODD_DELAY + 1);
  localparam logic [DW-1:0] LD_EVEN = DW'(EVEN_DELAY);
  localparam logic [DW-1:0] LD_ODD  = DW'(ODD_DELAY);
  localparam logic [DW-1:0] ONE     = DW'(1);

  logic          par;
  logic [DW-1:0] dly;

  assign apply = cyc_en && (dly == ONE) && !mode_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par     <= 1'b0;
      dly     <= '0;
      sh_five <= 1'b0;
      sh_inh  <= 1'b0;
    end else begin
      if (cyc_en) par <= ~par;
      if (mode_wr) begin
        dly     <= par ? LD_ODD : LD_EVEN;
        sh_five <= mode_bits[1];
        sh_inh  <= mode_bits[0];
      end else if (cyc_en && dly != '0) begin
        dly <= dly - ONE;
      end
    end
  end

  // R6
  delay_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !apply);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en && !mode_wr |=> $stable(dly) && $stable(par));

endmodule

// File: rtl/fseq_counter.sv
module fseq_counter
  import fseq_pkg::*;
#(
  parameter int STEP1 = 3729,
  parameter int STEP2 = 7457,
  parameter int STEP3 = 11186,
  parameter int STEP4 = 14915,
  parameter int STEP5 = 18641
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic apply,
  input  logic sh_five,
  output logic five,
  output logic irq_ev,
  output logic qtr_pulse,
  output logic half_pulse
);
  localparam int CW = $clog2(STEP5 + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] nxt;
  fseq_tick_t    tick;

  assign nxt  = cnt + CW'(1);
  assign tick = fseq_decode(five, 32'(nxt), STEP1, STEP2, STEP3, STEP4, STEP5);
  assign irq_ev = cyc_en && !apply && tick.irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      five       <= 1'b0;
      qtr_pulse  <= 1'b0;
      half_pulse <= 1'b0;
    end else if (apply) begin
      cnt        <= '0;
      five       <= sh_five;
      qtr_pulse  <= sh_five;
      half_pulse <= sh_five;
    end else if (cyc_en) begin
      cnt        <= tick.wrap ? '0 : nxt;
      qtr_pulse  <= tick.qtr;
      half_pulse <= tick.half;
    end else begin
      qtr_pulse  <= 1'b0;
      half_pulse <= 1'b0;
    end
  end

  // R3
  half_with_qtr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_pulse |-> qtr_pulse);

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> !qtr_pulse && !half_pulse);

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(STEP5));

endmodule

// File: rtl/fseq_irq.sv
module fseq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_ev,
  input  logic apply,
  input  logic sh_inh,
  input  logic mode_wr,
  input  logic wr_inh,
  input  logic stat_rd,
  output logic frame_irq,
  output logic irq_status
);
  logic inh;
  logic flag_d;

  always_comb begin
    flag_d = frame_irq;
    if (stat_rd) flag_d = 1'b0;
    if (irq_ev && !inh) flag_d = 1'b1;
    if (mode_wr && wr_inh) flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inh        <= 1'b0;
      frame_irq  <= 1'b0;
      irq_status <= 1'b0;
    end else begin
      if (apply) inh <= sh_inh;
      if (stat_rd) irq_status <= frame_irq;
      frame_irq <= flag_d;
    end
  end

  // R4
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_irq) |-> $past(irq_ev));

  // R8
  inh_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && wr_inh |=> !frame_irq);

  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !irq_ev |=> !frame_irq);

  // R9
  stat_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> irq_status == $past(frame_irq));

endmodule

// File: rtl/apu_frame_seq.sv
module apu_frame_seq #(
  parameter int STEP1      = 3729,
  parameter int STEP2      = 7457,
  parameter int STEP3      = 11186,
  parameter int STEP4      = 14915,
  parameter int STEP5      = 18641,
  parameter int EVEN_DELAY = 3,
  parameter int ODD_DELAY  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_en,
  input  logic       mode_wr,
  input  logic [1:0] mode_bits,
  input  logic       stat_rd,
  output logic       qtr_pulse,
  output logic       half_pulse,
  output logic       frame_irq,
  output logic       irq_status
);
  logic apply_w;
  logic sh_five_w;
  logic sh_inh_w;
  logic five_w;
  logic irq_ev_w;

  fseq_delay #(.EVEN_DELAY(EVEN_DELAY), .ODD_DELAY(ODD_DELAY)) u_delay (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .mode_wr(mode_wr),
    .mode_bits(mode_bits), .apply(apply_w), .sh_five(sh_five_w), .sh_inh(sh_inh_w)
  );

  fseq_counter #(.STEP1(STEP1), .STEP2(STEP2), .STEP3(STEP3), .STEP4(STEP4),
                 .STEP5(STEP5)) u_count (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .apply(apply_w), .sh_five(sh_five_w),
    .five(five_w), .irq_ev(irq_ev_w), .qtr_pulse(qtr_pulse), .half_pulse(half_pulse)
  );

  fseq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .irq_ev(irq_ev_w), .apply(apply_w), .sh_inh(sh_inh_w),
    .mode_wr(mode_wr), .wr_inh(mode_bits[0]), .stat_rd(stat_rd),
    .frame_irq(frame_irq), .irq_status(irq_status)
  );

  // R5
  no_irq_5step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_irq) |-> !$past(five_w));

endmodule

// File: tb/apu_frame_seq_test.sv
`timescale 1ns/1ps
module apu_frame_seq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_en;
  logic       mode_wr;
  logic [1:0] mode_bits;
  logic       stat_rd;
  logic       qtr_pulse, half_pulse, frame_irq, irq_status;

  int    n_tests = 0;
  int    n_fail  = 0;
  string tag     = "R1";
  bit    done    = 1'b0;

  apu_frame_seq uut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .mode_wr(mode_wr), .mode_bits(mode_bits),
    .stat_rd(stat_rd), .qtr_pulse(qtr_pulse), .half_pulse(half_pulse),
    .frame_irq(frame_irq), .irq_status(irq_status)
  );

  always #5 clk = ~clk;

  // Reference state
  int m_cnt, m_dly;
  bit m_five, m_inh, m_par, m_sh5, m_shi, m_flag, m_stat, m_q, m_h;

  // {irq, half, qtr} for the k-th enable since restart
  function automatic bit [2:0] exp_ev(bit five, int k);
    if (k == 3729 || k == 11186) return 3'b001;
    if (k == 7457) return 3'b011;
    if (k == 14915) return five ? 3'b000 : 3'b111;
    if (k == 18641 && five) return 3'b011;
    return 3'b000;
  endfunction

  function automatic int seq_len(bit five);
    return five ? 18641 : 14915;
  endfunction

  task automatic model_step(bit en, bit wr, bit [1:0] mb, bit rd);
    bit app;
    bit iev;
    bit [2:0] e;
    app = en && (m_dly == 1) && !wr;
    iev = 1'b0;
    m_q = 1'b0;
    m_h = 1'b0;
    if (app) begin
      m_cnt = 0; m_five = m_sh5; m_inh = m_shi; m_q = m_sh5; m_h = m_sh5;
    end else if (en) begin
      int k;
      k = m_cnt + 1;
      e = exp_ev(m_five, k);
      m_q = e[0]; m_h = e[1]; iev = e[2];
      m_cnt = (k == seq_len(m_five)) ? 0 : k;
    end
    if (rd) begin
      m_stat = m_flag;
      m_flag = 1'b0;
    end
    if (iev && !m_inh) m_flag = 1'b1;
    if (wr && mb[0]) m_flag = 1'b0;
    if (wr) begin
      m_dly = m_par ? 4 : 3; m_sh5 = mb[1]; m_shi = mb[0];
    end else if (en && m_dly != 0) m_dly = m_dly - 1;
    if (en) m_par = !m_par;
  endtask

  task automatic compare();
    n_tests++;
    if ({qtr_pulse, half_pulse, frame_irq, irq_status} !== {m_q, m_h, m_flag, m_stat}) begin
      n_fail++;
      $display("FAIL %s t=%0t q/h/irq/stat actual %b%b%b%b expected %b%b%b%b", tag, $time,
               qtr_pulse, half_pulse, frame_irq, irq_status, m_q, m_h, m_flag, m_stat);
    end
  endtask

  task automatic cyc(bit en, bit wr, bit [1:0] mb, bit rd);
    cyc_en = en; mode_wr = wr; mode_bits = mb; stat_rd = rd;
    @(posedge clk);
    @(negedge clk);
    model_step(en, wr, mb, rd);
    compare();
  endtask

  task automatic run(int n);
    repeat (n) cyc(1'b1, 1'b0, 2'b00, 1'b0);
  endtask

  task automatic set_par(bit p);
    if (m_par != p) cyc(1'b1, 1'b0, 2'b00, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; cyc_en = 1'b0; mode_wr = 1'b0; mode_bits = 2'b00; stat_rd = 1'b0;
    m_cnt = 0; m_dly = 0; m_five = 0; m_inh = 0; m_par = 0; m_sh5 = 0; m_shi = 0;
    m_flag = 0; m_stat = 0; m_q = 0; m_h = 0;
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 2'b00, 1'b0);

    // Four-step frame from reset: strobes and interrupt
    tag = "R2 R3 R4";
    run(15000);
    // Read acknowledges; then read exactly on the sequence end
    tag = "R9";
    cyc(1'b1, 1'b0, 2'b00, 1'b1);
    cyc(1'b0, 1'b0, 2'b00, 1'b1);
    while (m_cnt != 14914) cyc(1'b1, 1'b0, 2'b00, 1'b0);
    cyc(1'b1, 1'b0, 2'b00, 1'b1);
    run(5);

    // Inhibit write clears the pending flag immediately, then no further set
    tag = "R8";
    cyc(1'b0, 1'b1, 2'b01, 1'b0);
    run(15000);

    // Idle clocks near a step boundary
    tag = "R11";
    while (m_cnt != 3727) cyc(1'b1, 1'b0, 2'b00, 1'b0);
    repeat (20) cyc(1'b0, 1'b0, 2'b00, 1'b0);
    run(4);

    // Delayed restart on even and odd parity, five-step immediate strobes
    tag = "R6 R7";
    set_par(1'b0);
    cyc(1'b0, 1'b1, 2'b10, 1'b0);
    run(10);
    set_par(1'b1);
    cyc(1'b0, 1'b1, 2'b10, 1'b0);
    run(10);
    set_par(1'b0);
    cyc(1'b1, 1'b1, 2'b00, 1'b0);
    run(10);

    // A second write during the delay takes over
    tag = "R10";
    cyc(1'b1, 1'b1, 2'b00, 1'b0);
    cyc(1'b1, 1'b0, 2'b00, 1'b0);
    cyc(1'b1, 1'b1, 2'b10, 1'b0);
    run(10);

    // Five-step sequence, no interrupt across more than a frame
    tag = "R5";
    run(19000);
    cyc(1'b0, 1'b0, 2'b00, 1'b1);

    // Random mix
    tag = "R2 R5 R6 R8 R9 R10 R11";
    for (int i = 0; i < 40000; i++) begin
      bit en, wr, rd;
      bit [1:0] mb;
      en = ($urandom % 4) != 0;
      wr = ($urandom % 6000) == 0;
      rd = ($urandom % 40) == 0;
      mb = 2'($urandom % 4);
      cyc(en, wr, mb, rd);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule